// File: doc/BRIEF.md
# Selectable Multiphase Clock Generator

This block turns a fast input clock into up to four phase-shifted square waves. A prescaler first divides the input clock by 1, 10 or 100. Each time the prescaler completes one count it produces a single-cycle advance event. A small flip-flop phase machine steps once on every advance event. It drives two complementary outputs, three outputs spaced a third of a period apart, or four outputs in quadrature, depending on a 2-bit mode select.

Every output is a register. Outputs that the selected mode does not use stay low. When the divide select or the mode select changes, the block stores the new setting and clears both the prescaler and the phase machine. The new pattern then starts from its first step, so no mixed-mode state can leak onto the outputs. Reset is synchronous and active high.

Top module: `mphase_clkgen`

## Requirements
- R1: While `rst` is high, at each clock edge all four outputs are driven low and both internal counters are cleared. The settings on `div_sel` and `phase_sel` are captured at that edge.
- R2: `div_sel` = 00 makes an advance event on every clock. `div_sel` = 01 makes one every 10 clocks and `div_sel` = 10 makes one every 100 clocks. The first event comes N clocks after reset or after a setting change.
- R3: `div_sel` = 11 behaves exactly like `div_sel` = 10, dividing by 100.
- R4: Outputs change only at the clock edge of an advance event, or when the outputs are cleared.
- R5: `phase_sel` = 00 selects 2 phases. Successive advance events give `ph_out` = 0001, then 0010, and then repeat, so bit 0 and bit 1 are complementary.
- R6: `phase_sel` = 01 selects 3 phases. Successive advance events give 0001, 0010, then 0100, and then repeat.
- R7: `phase_sel` = 10 or 11 selects 4 phases. Successive advance events give 1001, 0011, 0110, then 1100, and then repeat. Each output is high for two events out of four, and bit k+1 lags bit k by one event (90 degrees).
- R8: Output bits at or above the selected phase count stay low.
- R9: If `div_sel` or `phase_sel` differs from the stored setting at a clock edge, the following happens at that edge. The new setting is stored, all outputs go low and no advance event takes place. The prescaler and the phase sequence then restart as they do after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 2 | Prescaler ratio: 00 gives /1, 01 gives /10, 1x gives /100 |
| phase_sel | input | 2 | Phase count: 00 gives 2, 01 gives 3, 1x gives 4 |
| ph_out | output | 4 | Phase outputs, bit 0 leading |

## Verification
The bench runs every phase mode at divide-by-1, where a wrong step order or a wrong active-bit mask shows up within a few clocks. It repeats the modes at divide-by-10 and divide-by-100, which checks the spacing between advance events separately from the pattern itself. The alias codes 11 on both selects are driven to show that they fold onto the defined modes. Setting changes are made in the middle of a sequence to check that the outputs clear and the sequence restarts from step 0, not from the old step. A mid-run reset is also applied to confirm that the prescaler and phase machine restart cleanly.

// File: rtl/mphase_pkg.sv
package mphase_pkg;

    localparam int NUM_PH = 4;

    typedef struct packed {
        logic [1:0] div;
        logic [1:0] mode;
    } cfg_t;

    // phases selected by a mode code: 00 -> 2, 01 -> 3, 1x -> 4
    function automatic logic [2:0] phase_count(input logic [1:0] mode);
        case (mode)
            2'b00:   phase_count = 3'd2;
            2'b01:   phase_count = 3'd3;
            default: phase_count = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/mphase_prescaler.sv
module mphase_prescaler #(
    parameter int MID_RATIO  = 10,
    parameter int HIGH_RATIO = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic [1:0] div,
    output logic       tick
);
    localparam int CW = $clog2(HIGH_RATIO);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        case (div)
            2'b00:   lim = '0;
            2'b01:   lim = CW'(MID_RATIO - 1);
            default: lim = CW'(HIGH_RATIO - 1);
        endcase
    end

    assign tick = (cnt == lim) && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mphase_ring.sv
module mphase_ring #(
    parameter int NOUT = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            adv,
    input  logic [2:0]      nph,
    output logic [NOUT-1:0] q
);
    localparam int CW = $clog2(NOUT);

    logic [CW-1:0]   step;
    logic [NOUT-1:0] nxt;
    logic [3:0]      n4;
    logic [3:0]      s4;

    assign n4 = {1'b0, nph};
    assign s4 = 4'(step);

    // bit k is high when (step - k) mod nph falls in the first half of the ring
    for (genvar k = 0; k < NOUT; k++) begin : g_bit
        logic [3:0] d;
        logic [3:0] w;
        always_comb begin
            d      = s4 + n4 - 4'(k);
            w      = (d >= n4) ? d - n4 : d;
            nxt[k] = (4'(k) < n4) && (w < (n4 >> 1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            step <= '0;
            q    <= '0;
        end else if (adv) begin
            q    <= nxt;
            step <= (s4 == n4 - 4'd1) ? '0 : step + 1'b1;
        end
    end
endmodule

// File: rtl/mphase_clkgen.sv
module mphase_clkgen
    import mphase_pkg::*;
#(
    parameter int MID_RATIO  = 10,
    parameter int HIGH_RATIO = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        div_sel,
    input  logic [1:0]        phase_sel,
    output logic [NUM_PH-1:0] ph_out
);
    cfg_t cfg_q;
    cfg_t cfg_in;
    logic chg;
    logic tick;

    assign cfg_in = '{div: div_sel, mode: phase_sel};
    assign chg    = (cfg_q != cfg_in);

    always_ff @(posedge clk) begin
        if (rst || chg)
            cfg_q <= cfg_in;
    end

    mphase_prescaler #(
        .MID_RATIO (MID_RATIO),
        .HIGH_RATIO(HIGH_RATIO)
    ) u_pre (
        .clk (clk),
        .rst (rst),
        .clr (chg),
        .div (cfg_q.div),
        .tick(tick)
    );

    mphase_ring #(
        .NOUT(NUM_PH)
    ) u_ring (
        .clk(clk),
        .rst(rst),
        .clr(chg),
        .adv(tick),
        .nph(phase_count(cfg_q.mode)),
        .q  (ph_out)
    );
endmodule

module mphase_clkgen_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] div_sel,
    input logic [1:0] phase_sel,
    input logic [3:0] ph_out,
    input logic [3:0] cfg_now,
    input logic       tick
);
    logic [3:0] live_mask;
    always_comb begin
        case (cfg_now[1:0])
            2'b00:   live_mask = 4'b0011;
            2'b01:   live_mask = 4'b0111;
            default: live_mask = 4'b1111;
        endcase
    end

    AST_UNUSED_LOW: assert property (@(posedge clk) disable iff (rst)
        (ph_out & ~live_mask) == 4'b0000); // R8
    AST_TWO_COMPL: assert property (@(posedge clk) disable iff (rst)
        (cfg_now[1:0] == 2'b00 && ph_out != 4'b0000) |-> $countones(ph_out[1:0]) == 1); // R5
    AST_THREE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (cfg_now[1:0] == 2'b01) |-> $onehot0(ph_out)); // R6
    AST_FOUR_PAIR: assert property (@(posedge clk) disable iff (rst)
        (cfg_now[1:0][1] && ph_out != 4'b0000) |-> $countones(ph_out) == 2); // R7
    AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cfg_now != {div_sel, phase_sel}) |=> ph_out == 4'b0000); // R9
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        (!tick && cfg_now == {div_sel, phase_sel}) |=> $stable(ph_out)); // R4
endmodule

bind mphase_clkgen mphase_clkgen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .div_sel  (div_sel),
    .phase_sel(phase_sel),
    .ph_out   (ph_out),
    .cfg_now  (cfg_q),
    .tick     (tick)
);

// File: tb/sim_mphase_clkgen.sv
module sim_mphase_clkgen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] div_sel = 2'b00;
    logic [1:0] phase_sel = 2'b00;
    logic [3:0] ph_out;

    always #2 clk = ~clk;  // 250 MHz

    mphase_clkgen u0 (
        .clk      (clk),
        .rst      (rst),
        .div_sel  (div_sel),
        .phase_sel(phase_sel),
        .ph_out   (ph_out)
    );

    typedef struct {
        logic [3:0] val;
        string      tag;
    } item_t;

    item_t exp_q[$];
    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    logic [3:0] m_cfg;
    int         m_pre = 0;
    int         m_step = 0;
    logic [3:0] m_out = 4'b0000;

    function automatic int ratio_of(input logic [1:0] d);
        if (d == 2'b00) return 1;
        if (d == 2'b01) return 10;
        return 100;   // R3: 10 and 11 both divide by 100
    endfunction

    function automatic int phases_of(input logic [1:0] m);
        if (m == 2'b00) return 2;
        if (m == 2'b01) return 3;
        return 4;
    endfunction

    function automatic logic [3:0] pattern(input int p, input int s);
        case (p)
            2:       return (s == 0) ? 4'b0001 : 4'b0010;
            3:       case (s) 0: return 4'b0001; 1: return 4'b0010; default: return 4'b0100; endcase
            default: case (s) 0: return 4'b1001; 1: return 4'b0011; 2: return 4'b0110; default: return 4'b1100; endcase
        endcase
    endfunction

    // driver: apply inputs for one clock and push the value expected after that edge
    task automatic step(input logic r, input logic [1:0] d, input logic [1:0] m, input string tag);
        item_t it;
        @(negedge clk);
        rst = r; div_sel = d; phase_sel = m;
        if (r || m_cfg !== {d, m}) begin
            m_cfg = {d, m}; m_pre = 0; m_step = 0; m_out = 4'b0000;
        end else if (m_pre == ratio_of(m_cfg[3:2]) - 1) begin
            m_pre  = 0;
            m_out  = pattern(phases_of(m_cfg[1:0]), m_step);
            m_step = (m_step + 1) % phases_of(m_cfg[1:0]);
        end else begin
            m_pre = m_pre + 1;
        end
        it.val = m_out; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic run(input int n, input logic [1:0] d, input logic [1:0] m, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, d, m, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                checks++;
                if (ph_out !== it.val) begin
                    errors++;
                    $display("FAIL %s: ph_out=%b expected %b at %0t", it.tag, ph_out, it.val, $time);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) step(1'b1, 2'b00, 2'b00, "R1 reset");
        run(8,   2'b00, 2'b00, "R2 R4 R5 R8 div1 2ph");
        run(9,   2'b00, 2'b01, "R2 R6 R8 R9 div1 3ph");
        run(12,  2'b00, 2'b10, "R2 R7 R9 div1 4ph");
        run(12,  2'b00, 2'b11, "R7 alias 4ph");
        run(90,  2'b01, 2'b10, "R2 R4 R7 div10 4ph");
        run(25,  2'b01, 2'b01, "R2 R4 R6 R8 div10 3ph");
        run(15,  2'b01, 2'b00, "R9 change mid-run");
        run(420, 2'b10, 2'b00, "R2 R4 R5 R8 div100 2ph");
        run(420, 2'b11, 2'b10, "R3 div alias 4ph");
        run(37,  2'b01, 2'b10, "R9 restart 4ph");
        for (int i = 0; i < 2; i++) step(1'b1, 2'b01, 2'b10, "R1 mid-run reset");
        run(30,  2'b01, 2'b10, "R1 R2 after reset");
        run(5,   2'b00, 2'b01, "R9 final change");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule